// File: doc/BRIEF.md
# Two-Wire Bus Master Condition Sequencer

This block is the master-side condition generator for a two-wire, open-drain serial bus. Software requests bus conditions by writing 1 to self-clearing control bits. The block then drives the clock and data lines through drive-low enables. A fresh start waits until the bus is free, then takes ownership of the bus. A repeated start is armed by the start bit and launched by a write to the data register. A stop releases the bus. Every timed phase lasts one programmable half period.

The block also provides a manual recovery path for a slave that has lost sync and holds the data line low. Writing 1 to the clock-toggle bit releases the clock drive for exactly one cycle, but only while the data line reads low. After a start, a one-cycle strobe tells the byte shifter to send the address byte. Byte shifting and arbitration are handled outside this block.

Top module: `twi_cond_master`

## Requirements
- R1: After reset, and on the cycle after `en_i` is low, all control bits read 0, both drive-low enables are 0 and `master_o` is 0. While `en_i` is low, control writes are discarded.
- R2: The control write word uses bit 0 = start, bit 1 = stop and bit 2 = clock toggle. `ctl_rd_o` returns the same three bits.
  - A start written while not owning the bus is held pending as long as `busy_i` is 1.
  - Once `busy_i` is 0, `sda_lo_o` rises while `scl_lo_o` stays 0, for H cycles. H is `half_per_i`, with 0 treated as 1.
  - `scl_lo_o` then rises, `master_o` becomes 1 and the start bit reads 0.
- R3: Addresses are launched by `addr_go_o`:
  - The first data write after a fresh start completes gives a one-cycle `addr_go_o` pulse in the following cycle.
  - A data write with no address pending, or while not owning the bus, gives no pulse.
- R4: While owning the bus, a set start bit changes nothing until a data write. That write starts three phases of H cycles each: data released with clock low, both lines released, then data low with clock released. Then both lines are held low, the start bit clears and `addr_go_o` pulses in that same cycle.
- R5: A stop written while owning the bus holds both lines low for the write cycle plus H cycles. It then releases the clock for H cycles with data low. After that both lines are released, `master_o` reads 0 and the stop bit clears. A pending stop is served before a pending repeated start. A stop write while not owning the bus is ignored.
- R6: `berr_i` clears the start and stop bits and `master_o`, and releases both lines on the next cycle.
- R7: Writing 1 to the toggle bit while `sda_i` is 0 sets the toggle bit and forces `scl_lo_o` to 0 for exactly one cycle, after which the bit clears. The write is ignored while `sda_i` is 1.
- R8: Writing 0 to any control bit changes no control bit and neither line.
- R9: `sda_rd_o` returns the level of `sda_i` sampled at the previous clock edge, whatever is written to the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable; low clears all state |
| half_per_i | input | HP_W | Half-period length in cycles (0 acts as 1) |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wd_i | input | 3 | Control write data: bit0 start, bit1 stop, bit2 clock toggle |
| dat_we_i | input | 1 | Data register write strobe |
| busy_i | input | 1 | Bus busy flag |
| berr_i | input | 1 | Bus error flag |
| sda_i | input | 1 | Synchronized data line level |
| sda_lo_o | output | 1 | Pull data line low |
| scl_lo_o | output | 1 | Pull clock line low |
| master_o | output | 1 | Block owns the bus |
| sda_rd_o | output | 1 | Sampled data line level |
| addr_go_o | output | 1 | One-cycle strobe launching the address byte |
| ctl_rd_o | output | 3 | Control bit readback, same layout as ctl_wd_i |

## Verification
The hardest situation to reach from the ports is a stop and a repeated start pending together while the bus is owned. The stimulus first completes a fresh start. It then raises the busy flag and writes both bits in one word. This shows that the stop sequence runs first and that the start bit survives it, still waiting on the busy flag. The clock-toggle release only shows up while the block holds the clock low, so the directed toggle checks run after ownership is taken. Constrained-random data-line levels with random toggle writes check the acceptance rule and the data-line sample.

// File: rtl/twi_cond_pkg.sv
package twi_cond_pkg;

  localparam int unsigned CTL_W     = 3;
  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_STOP  = 1;
  localparam int unsigned BIT_TGL   = 2;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ST_A = 3'd1,
    SQ_OWN  = 3'd2,
    SQ_RS_A = 3'd3,
    SQ_RS_B = 3'd4,
    SQ_RS_C = 3'd5,
    SQ_SP_A = 3'd6,
    SQ_SP_B = 3'd7
  } seq_state_e;

endpackage

// File: rtl/twi_half_timer.sv
module twi_half_timer #(
  parameter int unsigned HP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            load_i,
  input  logic [HP_W-1:0] half_i,
  output logic            expire_o
);

  logic [HP_W-1:0] cnt_q;
  logic [HP_W-1:0] cnt_d;

  // next-state: a load starts a window of max(half_i,1) cycles
  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (load_i) begin
      cnt_d = (half_i == '0) ? '0 : (half_i - HP_W'(1));
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - HP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/twi_ctl_bits.sv
module twi_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic berr_i,
  input  logic master_i,
  input  logic set_start_i,
  input  logic set_stop_i,
  input  logic start_done_i,
  input  logic stop_done_i,
  output logic start_o,
  output logic stop_o
);

  logic start_q, start_d;
  logic stop_q,  stop_d;

  always_comb begin
    start_d = start_q;
    if (!en_i || berr_i) begin
      start_d = 1'b0;
    end else if (start_done_i) begin
      start_d = 1'b0;
    end else if (set_start_i) begin
      start_d = 1'b1;
    end
  end

  // a stop request only lands while the bus is owned
  always_comb begin
    stop_d = stop_q;
    if (!en_i || berr_i) begin
      stop_d = 1'b0;
    end else if (stop_done_i) begin
      stop_d = 1'b0;
    end else if (set_stop_i && master_i) begin
      stop_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;

  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!start_q && !stop_q));

  assert_berr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    berr_i |=> (!start_q && !stop_q));

  assert_stop_owner_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(master_i));

endmodule

// File: rtl/twi_scl_recover.sv
module twi_scl_recover (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic wr_i,
  input  logic tgl_bit_i,
  input  logic sda_i,
  output logic tgl_o,
  output logic scl_rel_o
);

  logic tgl_q, tgl_d;

  // accepted only with the data line low; self-clears after one cycle
  always_comb begin
    tgl_d = 1'b0;
    if (en_i && !tgl_q && wr_i && tgl_bit_i && !sda_i) begin
      tgl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
    end else begin
      tgl_q <= tgl_d;
    end
  end

  assign tgl_o     = tgl_q;
  assign scl_rel_o = tgl_q;

  assert_tgl_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_q |=> !tgl_q);

  assert_tgl_needs_sda_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgl_q) |-> !$past(sda_i));

endmodule

// File: rtl/twi_cond_seq.sv
module twi_cond_seq
  import twi_cond_pkg::*;
#(
  parameter int unsigned HP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            berr_i,
  input  logic            busy_i,
  input  logic            dat_we_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [HP_W-1:0] half_i,
  output logic            sda_lo_o,
  output logic            scl_lo_o,
  output logic            master_o,
  output logic            addr_go_o,
  output logic            start_done_o,
  output logic            stop_done_o
);

  seq_state_e state_q, state_d;
  logic       master_q, master_d;
  logic       pend_q, pend_d;
  logic       go_q, go_d;
  logic       expire;
  logic       load;

  twi_half_timer #(.HP_W(HP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .load_i   (load),
    .half_i   (half_i),
    .expire_o (expire)
  );

  always_comb begin
    state_d      = state_q;
    master_d     = master_q;
    pend_d       = pend_q;
    go_d         = 1'b0;
    start_done_o = 1'b0;
    stop_done_o  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start_i && !busy_i) state_d = SQ_ST_A;
      end
      SQ_ST_A: begin
        if (expire) begin
          state_d      = SQ_OWN;
          master_d     = 1'b1;
          pend_d       = 1'b1;
          start_done_o = 1'b1;
        end
      end
      SQ_OWN: begin
        if (stop_i) begin
          state_d = SQ_SP_A;
        end else if (start_i && dat_we_i) begin
          state_d = SQ_RS_A;
          pend_d  = 1'b0;
        end else if (dat_we_i && pend_q) begin
          go_d   = 1'b1;
          pend_d = 1'b0;
        end
      end
      SQ_RS_A: if (expire) state_d = SQ_RS_B;
      SQ_RS_B: if (expire) state_d = SQ_RS_C;
      SQ_RS_C: begin
        if (expire) begin
          state_d      = SQ_OWN;
          go_d         = 1'b1;
          start_done_o = 1'b1;
        end
      end
      SQ_SP_A: if (expire) state_d = SQ_SP_B;
      SQ_SP_B: begin
        if (expire) begin
          state_d     = SQ_IDLE;
          master_d    = 1'b0;
          pend_d      = 1'b0;
          stop_done_o = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
    if (!en_i || berr_i) begin
      state_d      = SQ_IDLE;
      master_d     = 1'b0;
      pend_d       = 1'b0;
      go_d         = 1'b0;
      start_done_o = 1'b0;
      stop_done_o  = 1'b0;
    end
  end

  // every entry into a timed phase reloads the half-period counter
  always_comb begin
    load = (state_d != state_q) && (state_d != SQ_IDLE) && (state_d != SQ_OWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      master_q <= 1'b0;
      pend_q   <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      master_q <= master_d;
      pend_q   <= pend_d;
      go_q     <= go_d;
    end
  end

  // line drive per phase: start and stop only move data while clock is released
  always_comb begin
    sda_lo_o = 1'b0;
    scl_lo_o = 1'b0;
    case (state_q)
      SQ_ST_A: begin sda_lo_o = 1'b1; scl_lo_o = 1'b0; end
      SQ_OWN:  begin sda_lo_o = 1'b1; scl_lo_o = 1'b1; end
      SQ_RS_A: begin sda_lo_o = 1'b0; scl_lo_o = 1'b1; end
      SQ_RS_B: begin sda_lo_o = 1'b0; scl_lo_o = 1'b0; end
      SQ_RS_C: begin sda_lo_o = 1'b1; scl_lo_o = 1'b0; end
      SQ_SP_A: begin sda_lo_o = 1'b1; scl_lo_o = 1'b1; end
      SQ_SP_B: begin sda_lo_o = 1'b1; scl_lo_o = 1'b0; end
      default: begin sda_lo_o = 1'b0; scl_lo_o = 1'b0; end
    endcase
  end

  assign master_o  = master_q;
  assign addr_go_o = go_q;

  assert_start_from_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_q) |-> ($past(sda_lo_o) && !$past(scl_lo_o)));

  assert_busy_holds_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !berr_i && state_q == SQ_IDLE && busy_i) |=> state_q == SQ_IDLE);

  assert_go_only_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> master_q);

  assert_own_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_OWN && en_i && !berr_i && !dat_we_i && !stop_i)
      |=> ($stable(sda_lo_o) && $stable(scl_lo_o)));

  assert_release_on_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_q) |-> (!sda_lo_o && !scl_lo_o));

endmodule

// File: rtl/twi_cond_master.sv
module twi_cond_master
  import twi_cond_pkg::*;
#(
  parameter int unsigned HP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [HP_W-1:0]  half_per_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wd_i,
  input  logic             dat_we_i,
  input  logic             busy_i,
  input  logic             berr_i,
  input  logic             sda_i,
  output logic             sda_lo_o,
  output logic             scl_lo_o,
  output logic             master_o,
  output logic             sda_rd_o,
  output logic             addr_go_o,
  output logic [CTL_W-1:0] ctl_rd_o
);

  logic start_bit, stop_bit, tgl_bit;
  logic start_done, stop_done;
  logic seq_sda_lo, seq_scl_lo, scl_rel;
  logic set_start, set_stop;
  logic sda_smp_q;

  assign set_start = ctl_we_i && ctl_wd_i[BIT_START];
  assign set_stop  = ctl_we_i && ctl_wd_i[BIT_STOP];

  twi_ctl_bits u_bits (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .berr_i       (berr_i),
    .master_i     (master_o),
    .set_start_i  (set_start),
    .set_stop_i   (set_stop),
    .start_done_i (start_done),
    .stop_done_i  (stop_done),
    .start_o      (start_bit),
    .stop_o       (stop_bit)
  );

  twi_cond_seq #(.HP_W(HP_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .berr_i       (berr_i),
    .busy_i       (busy_i),
    .dat_we_i     (dat_we_i),
    .start_i      (start_bit),
    .stop_i       (stop_bit),
    .half_i       (half_per_i),
    .sda_lo_o     (seq_sda_lo),
    .scl_lo_o     (seq_scl_lo),
    .master_o     (master_o),
    .addr_go_o    (addr_go_o),
    .start_done_o (start_done),
    .stop_done_o  (stop_done)
  );

  twi_scl_recover u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .wr_i      (ctl_we_i),
    .tgl_bit_i (ctl_wd_i[BIT_TGL]),
    .sda_i     (sda_i),
    .tgl_o     (tgl_bit),
    .scl_rel_o (scl_rel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_smp_q <= 1'b0;
    end else begin
      sda_smp_q <= sda_i;
    end
  end

  assign sda_rd_o = sda_smp_q;
  assign sda_lo_o = seq_sda_lo;
  assign scl_lo_o = seq_scl_lo && !scl_rel;

  always_comb begin
    ctl_rd_o            = '0;
    ctl_rd_o[BIT_START] = start_bit;
    ctl_rd_o[BIT_STOP]  = stop_bit;
    ctl_rd_o[BIT_TGL]   = tgl_bit;
  end

  assert_idle_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sda_lo_o && !scl_lo_o && !master_o && ctl_rd_o == '0));

endmodule

// File: tb/twi_cond_master_test.sv
module twi_cond_master_test;

  localparam int CLK_PERIOD = 10;
  localparam int HP_W       = 8;

  logic            clk;
  logic            rst_n;
  logic            en_i;
  logic [HP_W-1:0] half_per_i;
  logic            ctl_we_i;
  logic [2:0]      ctl_wd_i;
  logic            dat_we_i;
  logic            busy_i;
  logic            berr_i;
  logic            sda_i;
  logic            sda_lo_o;
  logic            scl_lo_o;
  logic            master_o;
  logic            sda_rd_o;
  logic            addr_go_o;
  logic [2:0]      ctl_rd_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  twi_cond_master #(.HP_W(HP_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .half_per_i (half_per_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_wd_i   (ctl_wd_i),
    .dat_we_i   (dat_we_i),
    .busy_i     (busy_i),
    .berr_i     (berr_i),
    .sda_i      (sda_i),
    .sda_lo_o   (sda_lo_o),
    .scl_lo_o   (scl_lo_o),
    .master_o   (master_o),
    .sda_rd_o   (sda_rd_o),
    .addr_go_o  (addr_go_o),
    .ctl_rd_o   (ctl_rd_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_half(input int hp);
    return (hp == 0) ? 1 : hp;
  endfunction

  function automatic bit exp_tgl_taken(input bit wr_one, input bit sda);
    return wr_one && !sda;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [2:0] wd);
    ctl_we_i = 1'b1;
    ctl_wd_i = wd;
    @(negedge clk);
    ctl_we_i = 1'b0;
    ctl_wd_i = 3'b000;
  endtask

  task automatic dat_write();
    dat_we_i = 1'b1;
    @(negedge clk);
    dat_we_i = 1'b0;
  endtask

  task automatic count_phase(input bit sda_e, input bit scl_e, output int n);
    n = 0;
    while (sda_lo_o == sda_e && scl_lo_o == scl_e && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_start(input int hp, input int hold);
    int c;
    half_per_i = HP_W'(hp);
    busy_i = (hold > 0);
    ctl_write(3'b001);
    for (int i = 0; i < hold; i++) begin
      chk("R2 held while busy sda_lo", int'(sda_lo_o), 0);
      @(negedge clk);
    end
    if (hold > 0) chk("R2 start bit pending", int'(ctl_rd_o[0]), 1);
    busy_i = 1'b0;
    c = 0;
    while (!sda_lo_o && c < 50) begin
      c++;
      @(negedge clk);
    end
    count_phase(1'b1, 1'b0, c);
    chk("R2 start phase length", c, exp_half(hp));
    chk("R2 scl pulled after start", int'(scl_lo_o), 1);
    chk("R2 master after start", int'(master_o), 1);
    chk("R2 start bit self-clear", int'(ctl_rd_o[0]), 0);
  endtask

  task automatic do_stop(input int hp);
    int c;
    ctl_write(3'b010);
    count_phase(1'b1, 1'b1, c);
    chk("R5 stop first phase", c, exp_half(hp) + 1);
    count_phase(1'b1, 1'b0, c);
    chk("R5 stop second phase", c, exp_half(hp));
    chk("R5 lines released", int'({sda_lo_o, scl_lo_o}), 0);
    chk("R5 master cleared", int'(master_o), 0);
    chk("R5 stop bit self-clear", int'(ctl_rd_o[1]), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    bit s;
    bit w;
    void'($urandom(32'd4711));
    rst_n = 1'b0; en_i = 1'b0; half_per_i = 8'd3; ctl_we_i = 1'b0; ctl_wd_i = 3'b000;
    dat_we_i = 1'b0; busy_i = 1'b0; berr_i = 1'b0; sda_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset ctl bits", int'(ctl_rd_o), 0);
    chk("R1 reset lines", int'({sda_lo_o, scl_lo_o}), 0);
    chk("R1 reset master", int'(master_o), 0);
    en_i = 1'b1;
    @(negedge clk);

    // R8 zero write in idle, R5 stop not owner, R3 data write not owner
    ctl_write(3'b000);
    chk("R8 zero write idle", int'(ctl_rd_o), 0);
    ctl_write(3'b010);
    chk("R5 stop ignored when not owner", int'(ctl_rd_o), 0);
    dat_write();
    chk("R3 no launch when not owner", int'(addr_go_o), 0);

    // R2 fresh start held off by busy
    do_start(3, 5);

    // R3 address launch after fresh start
    dat_write();
    chk("R3 launch pulse", int'(addr_go_o), 1);
    @(negedge clk);
    chk("R3 launch one cycle", int'(addr_go_o), 0);
    dat_write();
    chk("R3 no second launch", int'(addr_go_o), 0);

    // R8 zero write while owner
    ctl_write(3'b000);
    chk("R8 zero write owner bits", int'(ctl_rd_o), 0);
    chk("R8 zero write owner lines", int'({sda_lo_o, scl_lo_o}), 3);

    // R7 toggle while owner
    sda_i = 1'b1;
    ctl_write(3'b100);
    chk("R7 toggle ignored sda high bit", int'(ctl_rd_o[2]), 0);
    chk("R7 toggle ignored sda high scl", int'(scl_lo_o), 1);
    sda_i = 1'b0;
    ctl_write(3'b100);
    chk("R7 toggle bit set", int'(ctl_rd_o[2]), 1);
    chk("R7 scl released", int'(scl_lo_o), 0);
    @(negedge clk);
    chk("R7 scl back low", int'(scl_lo_o), 1);
    chk("R7 toggle bit cleared", int'(ctl_rd_o[2]), 0);
    sda_i = 1'b1;

    // R4 repeated start
    ctl_write(3'b001);
    for (int i = 0; i < 4; i++) begin
      chk("R4 armed no change", int'({sda_lo_o, scl_lo_o}), 3);
      @(negedge clk);
    end
    chk("R4 start bit armed", int'(ctl_rd_o[0]), 1);
    dat_write();
    count_phase(1'b0, 1'b1, c);
    chk("R4 phase data released", c, 3);
    count_phase(1'b0, 1'b0, c);
    chk("R4 phase both released", c, 3);
    count_phase(1'b1, 1'b0, c);
    chk("R4 phase data low", c, 3);
    chk("R4 launch pulse", int'(addr_go_o), 1);
    chk("R4 start bit self-clear", int'(ctl_rd_o[0]), 0);
    chk("R4 lines held", int'({sda_lo_o, scl_lo_o}), 3);
    chk("R4 still owner", int'(master_o), 1);

    // R5 stop
    do_stop(3);

    // R2 R5 random half periods
    for (int k = 0; k < 4; k++) begin
      c = (k == 0) ? 0 : int'($urandom_range(1, 6));
      do_start(c, 0);
      do_stop(c);
    end

    // R5 stop served before pending repeated start
    do_start(2, 0);
    busy_i = 1'b1;
    ctl_write(3'b011);
    count_phase(1'b1, 1'b1, c);
    chk("R5 priority stop first phase", c, 3);
    count_phase(1'b1, 1'b0, c);
    chk("R5 priority stop second phase", c, 2);
    chk("R5 priority master cleared", int'(master_o), 0);
    chk("R5 priority start kept", int'(ctl_rd_o), 1);
    repeat (3) @(negedge clk);
    chk("R2 pending start waits busy", int'(sda_lo_o), 0);

    // R6 bus error clears pending start
    berr_i = 1'b1;
    @(negedge clk);
    berr_i = 1'b0;
    chk("R6 error clears start", int'(ctl_rd_o), 0);
    busy_i = 1'b0;

    // R6 bus error while owner
    do_start(2, 0);
    ctl_write(3'b001);
    berr_i = 1'b1;
    @(negedge clk);
    berr_i = 1'b0;
    chk("R6 error master", int'(master_o), 0);
    chk("R6 error lines", int'({sda_lo_o, scl_lo_o}), 0);
    chk("R6 error bits", int'(ctl_rd_o), 0);

    // R7 R9 random data-line levels with random toggle writes
    for (int k = 0; k < 40; k++) begin
      s = 1'($urandom_range(0, 1));
      w = 1'($urandom_range(0, 1));
      sda_i = s;
      ctl_write({w, 2'b00});
      chk("R9 sda sample", int'(sda_rd_o), int'(s));
      chk("R7 toggle acceptance", int'(ctl_rd_o[2]), int'(exp_tgl_taken(w, s)));
      @(negedge clk);
    end

    // R1 disable
    sda_i = 1'b1;
    do_start(1, 0);
    en_i = 1'b0;
    @(negedge clk);
    chk("R1 disable master", int'(master_o), 0);
    chk("R1 disable lines", int'({sda_lo_o, scl_lo_o}), 0);
    ctl_write(3'b001);
    chk("R1 write while disabled", int'(ctl_rd_o), 0);
    chk("R9 sample while disabled", int'(sda_rd_o), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule